// File: doc/BRIEF.md
# Synchronous Exception Trap Entry Unit

This unit records the trap state of a small hart with two privilege levels, machine and user, whenever a synchronous exception is taken. A one-cycle trap request arrives with a cause code, the address of the faulting instruction, the raw instruction word, the current delegation mask and the hart's current level. The unit picks the level that takes the trap. It then loads that level's exception PC, cause and trap-value registers in one clock edge, moves the hart to the chosen level, and clears its captured data-fault address.

The trap value depends on the cause. It is the raw PC for a misaligned fetch. For an illegal instruction it is the instruction word, or only its low half when the word is compressed. It is the captured data address for a misaligned load or store, and zero for every other cause. The surrounding pipeline sets the data-fault address with a capture strobe and can set the privilege level directly. A plain CSR write port and a combinational read port give access to the six trap registers.

Top module: `trap_csr_unit`

## Requirements
- R1: After reset all six trap registers read zero, the captured fault address is zero and `priv_out` reads 3 (machine).
- R2: The target level's exception PC receives `trap_pc` ANDed with `PC_MASK` (default clears bit 0).
- R3: An environment call (cause 11) is recorded as 8 plus the current level: 8 from user, 11 from machine. Other causes are recorded unchanged.
- R4: For cause 0 the trap value is `trap_pc`, unmasked.
- R5: For cause 2 the trap value is `trap_instr` when its bits [1:0] are both 1. Otherwise it is `trap_instr[15:0]`, zero-extended.
- R6: For cause 3 the trap value is zero.
- R7: For causes 4 and 6 the trap value is the captured fault address. `fault_cap_en` loads `fault_cap_addr` into that register.
- R8: For any cause other than 0, 2, 3, 4 and 6, the trap value is zero.
- R9: A trap clears the captured fault address at the same edge. A capture strobe in the same cycle as a trap is dropped, and that trap still sees the old captured value.
- R10: When the hart is in user mode and `deleg_mask` bit [recorded cause] is 1, the trap goes to the user registers. In every other case it goes to the machine registers. The mask has no effect in machine mode.
- R11: In the cycle after a trap request, `priv_out` reads the target level: 0 for user, 3 for machine.
- R12: A trap in the same cycle as a CSR write to any register of the target level discards that write. A CSR write to a register of the other level still takes effect. With no trap, a CSR write stores the data unchanged.
- R13: The cause register holds the recorded cause, zero-extended, with its top bit (interrupt flag) clear.
- R14: CSR addresses are 0x041/0x042/0x043 for user PC, cause and value, and 0x341/0x342/0x343 for the machine ones (the machine address is the user address ORed with level 3 shifted left by 8). Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | One-cycle synchronous exception request |
| trap_cause | input | CAUSE_W | Raw exception cause code |
| trap_pc | input | XLEN | Address of the faulting instruction |
| trap_instr | input | 32 | Raw faulting instruction word |
| deleg_mask | input | 2**CAUSE_W | Per-cause delegation to user level |
| fault_cap_en | input | 1 | Capture strobe for the data fault address |
| fault_cap_addr | input | XLEN | Data fault address to capture |
| mode_wr_en | input | 1 | Direct load of the privilege level |
| mode_wr_m | input | 1 | New level: 1 machine, 0 user |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_addr | input | 12 | CSR write address |
| csr_wr_data | input | XLEN | CSR write data |
| csr_rd_addr | input | 12 | CSR read address |
| csr_rd_data | output | XLEN | CSR read data (combinational) |
| priv_out | output | 2 | Current privilege level (0 or 3) |

## Verification
The hardest state to reach from the ports is a user-mode trap that lands in the user registers. It needs the level first dropped through the mode load, then a mask bit that matches the recorded cause, which for an environment call is 8 and not the raw 11. The vector table sets the level and the data fault address before every trap, so each entry starts from a known state. Directed steps then collide a trap with a same-cycle capture strobe and with CSR writes aimed at either level.

// File: rtl/trap_csr_unit.sv
module trap_csr_unit #(
  parameter int XLEN = 32,
  parameter int CAUSE_W = 5,
  parameter logic [XLEN-1:0] PC_MASK = ~XLEN'(1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trap_req,
  input  logic [CAUSE_W-1:0]      trap_cause,
  input  logic [XLEN-1:0]         trap_pc,
  input  logic [31:0]             trap_instr,
  input  logic [(1<<CAUSE_W)-1:0] deleg_mask,
  input  logic                    fault_cap_en,
  input  logic [XLEN-1:0]         fault_cap_addr,
  input  logic                    mode_wr_en,
  input  logic                    mode_wr_m,
  input  logic                    csr_wr_en,
  input  logic [11:0]             csr_wr_addr,
  input  logic [XLEN-1:0]         csr_wr_data,
  input  logic [11:0]             csr_rd_addr,
  output logic [XLEN-1:0]         csr_rd_data,
  output logic [1:0]              priv_out
);
  localparam logic [11:0] A_EPC = 12'h041;
  localparam logic [11:0] A_CAUSE = 12'h042;
  localparam logic [11:0] A_TVAL = 12'h043;

  logic            priv_m_q;
  logic [XLEN-1:0] fault_q;
  logic [XLEN-1:0] epc_q [2];
  logic [XLEN-1:0] cause_q [2];
  logic [XLEN-1:0] tval_q [2];

  logic [CAUSE_W-1:0] rec_cause;
  logic               to_machine;
  logic [XLEN-1:0]    tval_val;

  function automatic logic [11:0] lvl_addr(input int lvl, input logic [11:0] base);
    return (lvl == 1) ? (base | 12'h300) : base;
  endfunction

  assign rec_cause = (trap_cause == CAUSE_W'(11)) ?
                     (priv_m_q ? CAUSE_W'(11) : CAUSE_W'(8)) : trap_cause;
  assign to_machine = priv_m_q || !deleg_mask[rec_cause];
  assign priv_out = {2{priv_m_q}};

  always_comb begin
    case (trap_cause)
      CAUSE_W'(0):             tval_val = trap_pc;
      CAUSE_W'(2):             tval_val = (trap_instr[1:0] == 2'b11) ?
                                          XLEN'(trap_instr) : XLEN'(trap_instr[15:0]);
      CAUSE_W'(4), CAUSE_W'(6): tval_val = fault_q;
      default:                 tval_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_m_q <= 1'b1;
      fault_q  <= '0;
      for (int l = 0; l < 2; l++) begin
        epc_q[l]   <= '0;
        cause_q[l] <= '0;
        tval_q[l]  <= '0;
      end
    end else begin
      if (trap_req) fault_q <= '0;
      else if (fault_cap_en) fault_q <= fault_cap_addr;

      if (trap_req) priv_m_q <= to_machine;
      else if (mode_wr_en) priv_m_q <= mode_wr_m;

      for (int l = 0; l < 2; l++) begin
        if (trap_req && (to_machine == (l == 1))) begin
          epc_q[l]   <= trap_pc & PC_MASK;
          cause_q[l] <= XLEN'(rec_cause);
          tval_q[l]  <= tval_val;
        end else if (csr_wr_en) begin
          if (csr_wr_addr == lvl_addr(l, A_EPC))   epc_q[l]   <= csr_wr_data;
          if (csr_wr_addr == lvl_addr(l, A_CAUSE)) cause_q[l] <= csr_wr_data;
          if (csr_wr_addr == lvl_addr(l, A_TVAL))  tval_q[l]  <= csr_wr_data;
        end
      end
    end
  end

  always_comb begin
    csr_rd_data = '0;
    for (int l = 0; l < 2; l++) begin
      if (csr_rd_addr == lvl_addr(l, A_EPC))   csr_rd_data = epc_q[l];
      if (csr_rd_addr == lvl_addr(l, A_CAUSE)) csr_rd_data = cause_q[l];
      if (csr_rd_addr == lvl_addr(l, A_TVAL))  csr_rd_data = tval_q[l];
    end
  end
endmodule

module trap_csr_unit_chk #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] PC_MASK = ~XLEN'(1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            priv_m_q,
  input logic            to_machine,
  input logic [XLEN-1:0] fault_q,
  input logic [XLEN-1:0] mepc,
  input logic [XLEN-1:0] mcause,
  input logic [1:0]      priv_out
);
  // R11
  stay_machine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && priv_m_q |=> priv_out == 2'b11);
  // R10
  to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !to_machine |=> priv_out == 2'b00);
  // R9
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> fault_q == '0);
  // R2
  epc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && to_machine |=> (mepc & ~PC_MASK) == '0);
  // R13
  cause_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && to_machine |=> !mcause[XLEN-1]);
  // R11
  legal_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_out == 2'b00 || priv_out == 2'b11);
endmodule

bind trap_csr_unit trap_csr_unit_chk #(.XLEN(XLEN), .PC_MASK(PC_MASK)) chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .priv_m_q(priv_m_q),
  .to_machine(to_machine), .fault_q(fault_q), .mepc(epc_q[1]),
  .mcause(cause_q[1]), .priv_out(priv_out)
);

// File: tb/trap_csr_unit_test.sv
`timescale 1ns/1ps
module trap_csr_unit_test;
  logic clk = 0, rst_n = 0;
  logic trap_req = 0;
  logic [4:0] trap_cause = 0;
  logic [31:0] trap_pc = 0, trap_instr = 0, deleg_mask = 0;
  logic fault_cap_en = 0, mode_wr_en = 0, mode_wr_m = 0, csr_wr_en = 0;
  logic [31:0] fault_cap_addr = 0, csr_wr_data = 0, csr_rd_data;
  logic [11:0] csr_wr_addr = 0, csr_rd_addr = 0;
  logic [1:0] priv_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_csr_unit uut (.*);

  typedef struct packed {
    logic pm; logic [4:0] cause; logic [31:0] pc, instr, fault, deleg;
    logic tm; logic [4:0] ecause; logic [31:0] epc, tval;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd0,  32'h1003, 32'h0, 32'h0, 32'h0, 1'b1, 5'd0,  32'h1002, 32'h1003},
    '{1'b1, 5'd2,  32'h2000, 32'hDEADBEEF, 32'h0, 32'h0, 1'b1, 5'd2, 32'h2000, 32'hDEADBEEF},
    '{1'b1, 5'd2,  32'h2005, 32'h12344001, 32'h0, 32'h0, 1'b1, 5'd2, 32'h2004, 32'h4001},
    '{1'b1, 5'd3,  32'h3000, 32'h0, 32'h0, 32'h0, 1'b1, 5'd3,  32'h3000, 32'h0},
    '{1'b1, 5'd4,  32'h3100, 32'h0, 32'h80000010, 32'h0, 1'b1, 5'd4, 32'h3100, 32'h80000010},
    '{1'b1, 5'd6,  32'h3200, 32'h0, 32'h44, 32'h0, 1'b1, 5'd6, 32'h3200, 32'h44},
    '{1'b1, 5'd11, 32'h3300, 32'h0, 32'h0, 32'h0, 1'b1, 5'd11, 32'h3300, 32'h0},
    '{1'b0, 5'd11, 32'h3400, 32'h0, 32'h0, 32'h0, 1'b1, 5'd8,  32'h3400, 32'h0},
    '{1'b0, 5'd11, 32'h3500, 32'h0, 32'h0, 32'h100, 1'b0, 5'd8, 32'h3500, 32'h0},
    '{1'b0, 5'd4,  32'h3601, 32'h0, 32'h123, 32'h10, 1'b0, 5'd4, 32'h3600, 32'h123},
    '{1'b1, 5'd5,  32'h3700, 32'h0, 32'h55, 32'hFFFFFFFF, 1'b1, 5'd5, 32'h3700, 32'h0},
    '{1'b0, 5'd2,  32'h3800, 32'h00008002, 32'h0, 32'h4, 1'b0, 5'd2, 32'h3800, 32'h8002}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_rd_addr = a;
    #0.2;
    d = csr_rd_data;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); mode_wr_en = 1; mode_wr_m = m;
    @(negedge clk); mode_wr_en = 0;
  endtask

  task automatic capture(input logic [31:0] a);
    @(negedge clk); fault_cap_en = 1; fault_cap_addr = a;
    @(negedge clk); fault_cap_en = 0;
  endtask

  task automatic trap(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] ins,
                      input logic [31:0] dm);
    @(negedge clk);
    trap_req = 1; trap_cause = c; trap_pc = pc; trap_instr = ins; deleg_mask = dm;
    @(negedge clk);
    trap_req = 0; fault_cap_en = 0; csr_wr_en = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    foreach (VECS[i]) ; 
    for (int a = 0; a < 6; a++) begin
      rd((a < 3 ? 12'h041 : 12'h341) + 12'(a % 3), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset priv", {30'h0, priv_out}, 32'd3);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R11 R13
    for (int i = 0; i < NV; i++) begin
      set_mode(VECS[i].pm);
      if (VECS[i].fault != 0) capture(VECS[i].fault);
      trap(VECS[i].cause, VECS[i].pc, VECS[i].instr, VECS[i].deleg);
      base = VECS[i].tm ? 12'h340 : 12'h040;
      rd(base | 12'h1, d); chk("R2 epc", d, VECS[i].epc);
      rd(base | 12'h2, d); chk("R3/R13 cause", d, {27'h0, VECS[i].ecause});
      rd(base | 12'h3, d); chk("R4-R8 tval", d, VECS[i].tval);
      chk("R10/R11 priv", {30'h0, priv_out}, VECS[i].tm ? 32'd3 : 32'd0);
    end

    // R9: clear after trap, same-cycle capture dropped
    set_mode(1'b1);
    capture(32'h99);
    trap(5'd6, 32'h4000, 32'h0, 32'h0);
    rd(12'h343, d); chk("R7 captured tval", d, 32'h99);
    trap(5'd4, 32'h4100, 32'h0, 32'h0);
    rd(12'h343, d); chk("R9 cleared by trap", d, 32'h0);
    @(negedge clk); fault_cap_en = 1; fault_cap_addr = 32'hAA;
    trap_req = 1; trap_cause = 5'd4; trap_pc = 32'h4200;
    @(negedge clk); trap_req = 0; fault_cap_en = 0;
    rd(12'h343, d); chk("R9 trap sees old value", d, 32'h0);
    trap(5'd4, 32'h4300, 32'h0, 32'h0);
    rd(12'h343, d); chk("R9 same-cycle capture dropped", d, 32'h0);

    // R12: trap beats write to target level, other level write lands
    @(negedge clk); csr_wr_en = 1; csr_wr_addr = 12'h343; csr_wr_data = 32'hFFFF;
    trap_req = 1; trap_cause = 5'd0; trap_pc = 32'h500;
    @(negedge clk); trap_req = 0; csr_wr_en = 0;
    rd(12'h343, d); chk("R12 trap wins", d, 32'h500);
    @(negedge clk); csr_wr_en = 1; csr_wr_addr = 12'h041; csr_wr_data = 32'h7777;
    trap_req = 1; trap_cause = 5'd3; trap_pc = 32'h600;
    @(negedge clk); trap_req = 0; csr_wr_en = 0;
    rd(12'h041, d); chk("R12 other level write", d, 32'h7777);
    @(negedge clk); csr_wr_en = 1; csr_wr_addr = 12'h341; csr_wr_data = 32'h1235;
    @(negedge clk); csr_wr_en = 0;
    rd(12'h341, d); chk("R12 plain write unmasked", d, 32'h1235);

    // R14: unmapped address
    @(negedge clk); csr_wr_en = 1; csr_wr_addr = 12'h7C0; csr_wr_data = 32'h1;
    @(negedge clk); csr_wr_en = 0;
    rd(12'h7C0, d); chk("R14 unmapped reads zero", d, 32'h0);
    rd(12'h141, d); chk("R14 supervisor-like address zero", d, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule